// File: doc/BRIEF.md
# Message Interrupt Best-Pending Scanner

This block finds, for one processor core, the highest-priority pending message-signalled interrupt. Pending state lives in memory as a bitmap: byte `k` of the pending table holds the flags for interrupt IDs `8k` to `8k+7`, and bit `id % 8` is the flag for `id`. Each ID also has a one-byte configuration entry in a second table. That entry carries an enable flag and a priority field. The block walks the bitmap through a byte-wide memory port. For every set flag it fetches the configuration byte and keeps the best candidate in two output registers, `best_id` and `best_prio`.

Software or a neighbouring block sends commands through a one-cycle `cmd_valid` strobe while `busy` is low. There are four commands. A full scan rebuilds the result. A set or clear of a single pending flag updates memory and adjusts the result without a full rescan where possible. A move-all pulls every pending flag from a peer core's table into this core's table and then rescans. Message IDs start at 8192, so a scan starts at pending byte 1024. The table ends at `2^(e+1)` IDs, where `e` is the smaller of the `id_bits` field and the `IMPL_IDBITS` parameter.

Top module: `pend_best_scan`

## Requirements
- R1: After reset `best_prio` is 0xFF, `best_id` is 0, and `busy`, `done` and `mem_req` are low.
- R2: A full scan (`cmd_op` 0) reads pending bytes at `pend_base + k` for `k` from 1024 up to `2^(e+1)/8 - 1`, with `e = min(id_bits, IMPL_IDBITS)`. It starts from priority 0xFF and ID 0, and leaves the best enabled pending ID in the outputs. If the table holds no more than 8192 IDs, no byte is read.
- R3: The configuration byte for ID `n` is read at `prop_base + n - 8192`. An entry whose bit 0 is 0 is disabled and never becomes the result.
- R4: With `sec_off` high the priority is `cfg & 0xFC`. With `sec_off` low it is `((cfg & 0xFC) >> 1) | 0x80`.
- R5: A candidate replaces the current result when its priority is numerically lower, or when its priority is equal and its ID is not larger.
- R6: While `msg_en` is low every command completes with a `done` pulse, makes no memory access, and leaves the result unchanged.
- R7: A set (`cmd_op` 1) or clear (`cmd_op` 2) whose ID is below 8192, or is not below `2^(e+1)`, makes no memory access.
- R8: A set reads the pending byte. If the flag is already 1, nothing is written. Otherwise the byte is written back with the flag set, and only that ID is compared against the current result.
- R9: A clear of a flag that is 1 writes the byte back with the flag cleared. A full rescan follows only if the ID equals `best_id`.
- R10: A move-all (`cmd_op` 3) needs both `msg_en` and `peer_msg_en`. For each byte index in the common range (the smaller of the two table sizes), a non-zero peer byte is ORed into this core's byte, and then the peer byte is written to 0. A full scan of this core's table follows.
- R11: `mem_req` stays high with a stable address, direction and data until `mem_ack`. `busy` is high from the cycle after a command is accepted until `done`. `done` is a one-cycle pulse with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_en | input | 1 | Message interrupts enabled for this core |
| peer_msg_en | input | 1 | Message interrupts enabled on the peer core |
| sec_off | input | 1 | Security disabled: use the unshifted priority |
| id_bits | input | IDF_W | Programmed ID-bits field for this core |
| peer_id_bits | input | IDF_W | Programmed ID-bits field for the peer core |
| prop_base | input | AW | Configuration table base address |
| pend_base | input | AW | This core's pending table base address |
| peer_pend_base | input | AW | Peer core's pending table base address |
| cmd_valid | input | 1 | Command strobe, taken while busy is low |
| cmd_op | input | 2 | 0 scan, 1 set, 2 clear, 3 move-all |
| cmd_id | input | IMPL_IDBITS+1 | Interrupt ID for set and clear |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completed (pulse) |
| best_id | output | IMPL_IDBITS+1 | Best pending ID |
| best_prio | output | 8 | Its priority, 0xFF when there is none |

## Verification
The assertions check the memory handshake on every cycle: a request holds steady until its acknowledge, and there is no request while idle. They also check that `done` is a lone pulse, that the result never moves while idle, and that any recorded priority has the form the masking gives. Only the bench scenarios can show what the result should be: that ties go to the lower ID, that disabled entries are skipped, that a set of an already-set flag writes nothing, that the clamped table size bounds the scan, and that a move-all leaves the exact expected bytes in both tables.

// File: rtl/pend_scan_pkg.sv
package pend_scan_pkg;
  typedef enum logic [1:0] {
    OP_SCAN = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_MOVE = 2'd3
  } scan_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SC_INIT, S_SC_RD, S_SC_BIT, S_SC_CFG,
    S_UP_RD, S_UP_WR, S_UP_CFG,
    S_MV_RDS, S_MV_RDD, S_MV_WRD, S_MV_WRS, S_FIN
  } scan_st_e;

  localparam logic [7:0] PRIO_FIELD_MASK = 8'hFC;
  localparam logic [7:0] PRIO_EMPTY      = 8'hFF;
endpackage

// File: rtl/pend_bit_pick.sv
module pend_bit_pick #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  // lowest set bit wins: walk downward so the last hit is the lowest
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pend_prio_eval.sv
module pend_prio_eval
  import pend_scan_pkg::*;
#(
  parameter int IDW = 14
) (
  input  logic [7:0]     cfg_byte,
  input  logic           sec_off,
  input  logic [IDW-1:0] cand_id,
  input  logic [7:0]     cur_prio,
  input  logic [IDW-1:0] cur_id,
  output logic           take,
  output logic [7:0]     cand_prio
);
  logic [7:0] masked;
  logic       better;

  always_comb begin
    masked    = cfg_byte & PRIO_FIELD_MASK;
    cand_prio = sec_off ? masked : {1'b1, masked[7:1]};
    better    = (cand_prio < cur_prio) ||
                ((cand_prio == cur_prio) && (cand_id <= cur_id));
    take      = cfg_byte[0] && better;
  end
endmodule

// File: rtl/pend_mem_port.sv
module pend_mem_port #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [7:0]    go_wdata,
  output logic          fin,
  output logic [7:0]    rd_byte,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      fin       <= 1'b0;
      rd_byte   <= '0;
    end else begin
      fin <= 1'b0;
      if (mem_req) begin
        if (mem_ack) begin
          mem_req <= 1'b0;
          fin     <= 1'b1;
          rd_byte <= mem_rdata;
        end
      end else if (go) begin
        mem_req   <= 1'b1;
        mem_we    <= go_we;
        mem_addr  <= go_addr;
        mem_wdata <= go_wdata;
      end
    end
  end
endmodule

// File: rtl/pend_best_scan.sv
module pend_best_scan
  import pend_scan_pkg::*;
#(
  parameter int AW          = 20,
  parameter int IMPL_IDBITS = 13,
  parameter int IDF_W       = 5,
  parameter int LPI_BASE    = 8192
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   msg_en,
  input  logic                   peer_msg_en,
  input  logic                   sec_off,
  input  logic [IDF_W-1:0]       id_bits,
  input  logic [IDF_W-1:0]       peer_id_bits,
  input  logic [AW-1:0]          prop_base,
  input  logic [AW-1:0]          pend_base,
  input  logic [AW-1:0]          peer_pend_base,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [IMPL_IDBITS:0]   cmd_id,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [7:0]             mem_wdata,
  input  logic                   mem_ack,
  input  logic [7:0]             mem_rdata,
  output logic                   busy,
  output logic                   done,
  output logic [IMPL_IDBITS:0]   best_id,
  output logic [7:0]             best_prio
);
  localparam int IDW = IMPL_IDBITS + 1;
  localparam int BW  = IDW - 3;
  localparam logic [BW:0]      FIRST_B = (BW+1)'(LPI_BASE / 8);
  localparam logic [IDW-1:0]   LPI_ID  = IDW'(LPI_BASE);
  localparam logic [IDF_W-1:0] IMPL_F  = IDF_W'(IMPL_IDBITS);

  // number of pending-table bytes for a programmed ID-bits field
  function automatic logic [BW:0] tbl_bytes(input logic [IDF_W-1:0] f);
    logic [IDF_W-1:0] e;
    e = (f > IMPL_F) ? IMPL_F : f;
    if (e < IDF_W'(2)) return '0;
    return (BW+1)'(1) << (e - IDF_W'(2));
  endfunction

  scan_st_e       st;
  logic           mem_wait;
  logic [BW:0]    byte_idx, lim_q;
  logic [7:0]     work, src_b;
  logic [IDW-1:0] cur_id, best_id_q;
  logic [7:0]     best_prio_q;
  logic           upd_set, busy_q, done_q;

  logic [BW:0]    lim_own, lim_peer, lim_move;
  logic           last_byte, id_ok;
  logic [2:0]     pick;
  logic [7:0]     upd_mask;

  logic           m_go, m_we, m_fin;
  logic [AW-1:0]  m_addr;
  logic [7:0]     m_wd, m_rd;
  logic           take;
  logic [7:0]     cand_prio;

  always_comb begin
    lim_own   = tbl_bytes(id_bits);
    lim_peer  = tbl_bytes(peer_id_bits);
    lim_move  = (lim_peer < lim_own) ? lim_peer : lim_own;
    last_byte = (byte_idx == lim_q - 1'b1);
    id_ok     = (cmd_id >= LPI_ID) && ({1'b0, cmd_id[IDW-1:3]} < lim_own);
    upd_mask  = 8'(1) << cur_id[2:0];
  end

  pend_bit_pick #(.W(8)) u_pick (
    .vec (work),
    .idx (pick)
  );

  pend_prio_eval #(.IDW(IDW)) u_eval (
    .cfg_byte  (m_rd),
    .sec_off   (sec_off),
    .cand_id   (cur_id),
    .cur_prio  (best_prio_q),
    .cur_id    (best_id_q),
    .take      (take),
    .cand_prio (cand_prio)
  );

  // memory request selection per state
  always_comb begin
    m_go   = 1'b0;
    m_we   = 1'b0;
    m_addr = '0;
    m_wd   = '0;
    unique case (st)
      S_SC_RD: begin
        m_go   = 1'b1;
        m_addr = pend_base + AW'(byte_idx);
      end
      S_SC_CFG, S_UP_CFG: begin
        m_go   = 1'b1;
        m_addr = prop_base + AW'(cur_id - LPI_ID);
      end
      S_UP_RD: begin
        m_go   = 1'b1;
        m_addr = pend_base + AW'(cur_id[IDW-1:3]);
      end
      S_UP_WR: begin
        m_go   = 1'b1;
        m_we   = 1'b1;
        m_addr = pend_base + AW'(cur_id[IDW-1:3]);
        m_wd   = upd_set ? (work | upd_mask) : (work & ~upd_mask);
      end
      S_MV_RDS: begin
        m_go   = 1'b1;
        m_addr = peer_pend_base + AW'(byte_idx);
      end
      S_MV_RDD: begin
        m_go   = 1'b1;
        m_addr = pend_base + AW'(byte_idx);
      end
      S_MV_WRD: begin
        m_go   = 1'b1;
        m_we   = 1'b1;
        m_addr = pend_base + AW'(byte_idx);
        m_wd   = work | src_b;
      end
      S_MV_WRS: begin
        m_go   = 1'b1;
        m_we   = 1'b1;
        m_addr = peer_pend_base + AW'(byte_idx);
        m_wd   = 8'h00;
      end
      default: m_go = 1'b0;
    endcase
    m_go = m_go && !mem_wait;
  end

  pend_mem_port #(.AW(AW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .go        (m_go),
    .go_we     (m_we),
    .go_addr   (m_addr),
    .go_wdata  (m_wd),
    .fin       (m_fin),
    .rd_byte   (m_rd),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      mem_wait    <= 1'b0;
      byte_idx    <= '0;
      lim_q       <= '0;
      work        <= '0;
      src_b       <= '0;
      cur_id      <= '0;
      upd_set     <= 1'b0;
      best_id_q   <= '0;
      best_prio_q <= PRIO_EMPTY;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (m_go) mem_wait <= 1'b1;
      else if (m_fin) mem_wait <= 1'b0;

      unique case (st)
        S_IDLE: if (cmd_valid) begin
          busy_q <= 1'b1;
          unique case (scan_op_e'(cmd_op))
            OP_SCAN: st <= S_SC_INIT;
            OP_SET, OP_CLR: begin
              cur_id  <= cmd_id;
              upd_set <= (cmd_op == OP_SET);
              st      <= (msg_en && id_ok) ? S_UP_RD : S_FIN;
            end
            default: begin
              byte_idx <= FIRST_B;
              lim_q    <= lim_move;
              if (!(msg_en && peer_msg_en)) st <= S_FIN;
              else st <= (lim_move > FIRST_B) ? S_MV_RDS : S_SC_INIT;
            end
          endcase
        end
        S_SC_INIT: begin
          if (!msg_en) st <= S_FIN;
          else begin
            best_prio_q <= PRIO_EMPTY;
            best_id_q   <= '0;
            byte_idx    <= FIRST_B;
            lim_q       <= lim_own;
            st          <= (lim_own > FIRST_B) ? S_SC_RD : S_FIN;
          end
        end
        S_SC_RD: if (m_fin) begin
          work <= m_rd;
          st   <= S_SC_BIT;
        end
        S_SC_BIT: begin
          if (work == 8'h00) begin
            if (last_byte) st <= S_FIN;
            else begin
              byte_idx <= byte_idx + 1'b1;
              st       <= S_SC_RD;
            end
          end else begin
            cur_id <= {byte_idx[BW-1:0], pick};
            work   <= work & ~(8'(1) << pick);
            st     <= S_SC_CFG;
          end
        end
        S_SC_CFG: if (m_fin) begin
          if (take) begin
            best_id_q   <= cur_id;
            best_prio_q <= cand_prio;
          end
          st <= S_SC_BIT;
        end
        S_UP_RD: if (m_fin) begin
          work <= m_rd;
          st   <= ((m_rd & upd_mask) != 8'h00) == upd_set ? S_FIN : S_UP_WR;
        end
        S_UP_WR: if (m_fin) begin
          if (upd_set) st <= S_UP_CFG;
          else st <= (cur_id == best_id_q) ? S_SC_INIT : S_FIN;
        end
        S_UP_CFG: if (m_fin) begin
          if (take) begin
            best_id_q   <= cur_id;
            best_prio_q <= cand_prio;
          end
          st <= S_FIN;
        end
        S_MV_RDS: if (m_fin) begin
          src_b <= m_rd;
          if (m_rd != 8'h00) st <= S_MV_RDD;
          else if (last_byte) st <= S_SC_INIT;
          else begin
            byte_idx <= byte_idx + 1'b1;
            st       <= S_MV_RDS;
          end
        end
        S_MV_RDD: if (m_fin) begin
          work <= m_rd;
          st   <= S_MV_WRD;
        end
        S_MV_WRD: if (m_fin) st <= S_MV_WRS;
        S_MV_WRS: if (m_fin) begin
          if (last_byte) st <= S_SC_INIT;
          else begin
            byte_idx <= byte_idx + 1'b1;
            st       <= S_MV_RDS;
          end
        end
        default: begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
      endcase
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign best_id   = best_id_q;
  assign best_prio = best_prio_q;
endmodule

// File: rtl/pend_best_scan_chk.sv
module pend_best_scan_chk #(
  parameter int AW  = 20,
  parameter int IDW = 14
) (
  input logic           clk,
  input logic           rst,
  input logic           cmd_valid,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [7:0]     mem_wdata,
  input logic           mem_ack,
  input logic           busy,
  input logic           done,
  input logic [IDW-1:0] best_id,
  input logic [7:0]     best_prio
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_no_req_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  p_prio_form_r4: assert property (@(posedge clk) disable iff (rst)
    (best_prio != 8'hFF) |-> (best_prio[0] == 1'b0));

  p_best_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cmd_valid) |=> ($stable(best_prio) && $stable(best_id)));
endmodule

bind pend_best_scan pend_best_scan_chk #(.AW(AW), .IDW(IMPL_IDBITS + 1)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .busy      (busy),
  .done      (done),
  .best_id   (best_id),
  .best_prio (best_prio)
);

// File: tb/pend_best_scan_tb_top.sv
`timescale 1ns/1ps
module pend_best_scan_tb_top;
  localparam int AW = 20;
  localparam int WD_LIMIT = 150000;
  localparam int PROP = 32'h10000;
  localparam int PEND = 32'h00000;
  localparam int PEER = 32'h08000;

  // {id[15:0], cfg[7:0], exp_id[15:0], exp_prio[7:0]} applied as set commands
  localparam logic [47:0] VEC [0:5] = '{
    48'h2008_41_2008_40,
    48'h206C_81_2008_40,
    48'h2003_41_2003_40,
    48'h203A_40_2003_40,
    48'h2328_23_2328_20,
    48'h2329_22_2328_20
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic msg_en = 1'b0, peer_msg_en = 1'b0, sec_off = 1'b1;
  logic [4:0] id_bits = 5'd13, peer_id_bits = 5'd13;
  logic [AW-1:0] prop_base = AW'(PROP), pend_base = AW'(PEND), peer_pend_base = AW'(PEER);
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [13:0] cmd_id = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 8'h00;
  logic busy, done;
  logic [13:0] best_id;
  logic [7:0] best_prio;

  int checks = 0, errors = 0, cyc = 0;
  int rd_n = 0, wr_n = 0, req_seq = 0, wait_cnt = 0, max_pend_rd = 0;
  bit saw_busy;
  logic [7:0] mem [int unsigned];

  always #2.5 clk = ~clk;

  pend_best_scan dut_i (
    .clk(clk), .rst(rst), .msg_en(msg_en), .peer_msg_en(peer_msg_en), .sec_off(sec_off),
    .id_bits(id_bits), .peer_id_bits(peer_id_bits), .prop_base(prop_base),
    .pend_base(pend_base), .peer_pend_base(peer_pend_base),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .best_id(best_id), .best_prio(best_prio)
  );

  function automatic logic [7:0] mrd(int unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  // memory model: variable latency 0..3 negedges, one access per ack
  always @(negedge clk) begin
    cyc++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_cnt >= (req_seq % 4)) begin
        if (mem_we) begin
          mem[int'(mem_addr)] = mem_wdata;
          wr_n++;
        end else begin
          mem_rdata = mrd(int'(mem_addr));
          rd_n++;
          if (int'(mem_addr) < PEER && int'(mem_addr) > max_pend_rd) max_pend_rd = int'(mem_addr);
        end
        mem_ack = 1'b1;
        req_seq++;
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(negedge clk) begin
    if (cyc >= WD_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog R11 act=%0d exp<%0d", cyc, WD_LIMIT);
      report();
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_cmd(logic [1:0] op, logic [13:0] id);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_id = id;
    @(negedge clk);
    cmd_valid = 1'b0;
    saw_busy = busy;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int r0, w0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 prio", 32'(best_prio), 32'hFF);
    check("R1 id", 32'(best_id), 32'h0);
    check("R1 busy/done/req", {29'd0, busy, done, mem_req}, 32'h0);

    msg_en = 1'b1;
    peer_msg_en = 1'b1;
    // R2 empty table scan reads exactly bytes 1024..2047
    r0 = rd_n;
    run_cmd(2'd0, '0);
    check("R11 busy during scan", 32'(saw_busy), 32'h1);
    check("R2 empty scan reads", 32'(rd_n - r0), 32'd1024);
    check("R2 empty scan prio", 32'(best_prio), 32'hFF);

    // vector walk: R8 set, R3 enable/addr, R5 ordering
    foreach (VEC[i]) begin
      mem[PROP + int'(VEC[i][47:32]) - 8192] = VEC[i][31:24];
      run_cmd(2'd1, VEC[i][45:32]);
      check($sformatf("R8 R5 R3 vector %0d", i), {8'd0, 2'b00, best_id, best_prio},
            {8'd0, VEC[i][23:0]});
    end
    check("R8 pending flag written", 32'(mrd(PEND + 1037)), 32'h10);

    // R2 clamp: id_bits above implemented maximum
    id_bits = 5'd31;
    r0 = rd_n;
    run_cmd(2'd0, '0);
    check("R2 clamp reads", 32'(rd_n - r0), 32'd1030);
    check("R2 clamp bound", 32'(max_pend_rd), 32'd2047);
    check("R2 R5 scan result", {10'd0, best_id, best_prio}, {10'd0, 14'd9000, 8'h20});

    // R2 small table: nothing read; R7 set out of range
    id_bits = 5'd12;
    r0 = rd_n;
    run_cmd(2'd0, '0);
    check("R2 small table prio", 32'(best_prio), 32'hFF);
    run_cmd(2'd1, 14'd8200);
    check("R7 beyond table no access", 32'(rd_n - r0), 32'd0);
    id_bits = 5'd13;
    run_cmd(2'd0, '0);
    check("R2 restore scan", {10'd0, best_id, best_prio}, {10'd0, 14'd9000, 8'h20});

    // R9 clear of a non-best flag: one read, one write, no rescan
    r0 = rd_n; w0 = wr_n;
    run_cmd(2'd2, 14'd8300);
    check("R9 clear reads", 32'(rd_n - r0), 32'd1);
    check("R9 clear writes", 32'(wr_n - w0), 32'd1);
    check("R9 flag cleared", 32'(mrd(PEND + 1037)), 32'h00);
    check("R9 best kept", {10'd0, best_id, best_prio}, {10'd0, 14'd9000, 8'h20});

    // R8 set of an already-set flag: no write
    w0 = wr_n;
    run_cmd(2'd1, 14'd8200);
    check("R8 no write when set", 32'(wr_n - w0), 32'd0);

    // R7 ID below 8192
    r0 = rd_n;
    run_cmd(2'd1, 14'd100);
    check("R7 low id no access", 32'(rd_n - r0), 32'd0);

    // R9 clear of the best: rescan
    run_cmd(2'd2, 14'd9000);
    check("R9 rescan result", {10'd0, best_id, best_prio}, {10'd0, 14'd8195, 8'h40});

    // R4 secure priority transform
    sec_off = 1'b0;
    run_cmd(2'd0, '0);
    check("R4 secure prio", {10'd0, best_id, best_prio}, {10'd0, 14'd8195, 8'hA0});
    sec_off = 1'b1;

    // R6 disabled: scan and set do nothing
    msg_en = 1'b0;
    r0 = rd_n; w0 = wr_n;
    run_cmd(2'd0, '0);
    run_cmd(2'd1, 14'd8400);
    check("R6 no access", 32'(rd_n - r0 + wr_n - w0), 32'd0);
    check("R6 best kept", {10'd0, best_id, best_prio}, {10'd0, 14'd8195, 8'hA0});
    msg_en = 1'b1;

    // R10 move-all setup
    mem[PEER + 1030] = 8'h05;
    mem[PEER + 1500] = 8'h80;
    mem[PEND + 1500] = 8'h02;
    mem[PROP + 48] = 8'h11;
    mem[PROP + 50] = 8'h31;
    mem[PROP + 3815] = 8'h09;
    mem[PROP + 3809] = 8'h00;
    peer_msg_en = 1'b0;
    w0 = wr_n;
    run_cmd(2'd3, '0);
    check("R10 peer disabled no write", 32'(wr_n - w0), 32'd0);
    check("R10 peer byte kept", 32'(mrd(PEER + 1030)), 32'h05);
    peer_msg_en = 1'b1;
    run_cmd(2'd3, '0);
    check("R10 own byte 1030", 32'(mrd(PEND + 1030)), 32'h05);
    check("R10 own byte 1500", 32'(mrd(PEND + 1500)), 32'h82);
    check("R10 peer zeroed", {16'd0, mrd(PEER + 1030), mrd(PEER + 1500)}, 32'h0);
    check("R10 rescan result", {10'd0, best_id, best_prio}, {10'd0, 14'd12007, 8'h08});

    report();
    $finish;
  end
endmodule